// File: doc/BRIEF.md
# SPI Register-Access Slave with Switchable 3-Wire Data Line

This block lets an SPI host read and write a file of 128 byte-wide registers. Each transaction begins when chip select falls. A command byte comes first: a direction bit followed by a 7-bit register address. One or more data bytes follow, and the transaction ends when chip select rises. The serial clock idles high. The host changes its data after each falling clock edge, and the slave samples on each rising edge. Read data from the slave likewise changes after a falling edge and is valid by the next rising edge.

Two bits of a control register set how the block behaves at run time. The first chooses which line carries read data: a separate output line (4-wire), or the shared input line turned around (3-wire). The second chooses whether the register address steps by one after each data byte, which allows bursts of any length. The register at 0Fh is a fixed identity value. The serial clock, chip select and data inputs are brought into a faster system clock domain through synchronizer flops. All decoding is done on the synchronized edges.

The control FSM has four states. IDLE waits for chip select to fall (transition START) and then enters CMD. CMD collects eight command bits. On the eighth rising edge it goes to WDATA (transition TO_WRITE, direction 0) or to RDATA (transition TO_READ, direction 1). WDATA commits one byte per eight rising edges. RDATA shifts one byte out per eight falling edges. From every non-idle state, chip select high leads back to IDLE (transition ABORT/END).

Top module: `spireg_top`

## Requirements
- R1: The command byte is sent MSB first. Its first bit is the direction bit, where 1 means read and 0 means write. Its next seven bits are the register address, MSB first.
- R2: In a write, each complete data byte of eight rising clock edges is stored at the current address. A single write takes 16 clock pulses: 8 command bits and 8 data bits.
- R3: In a read, the register value is sent MSB first. Each bit changes after a falling clock edge and is valid at the following rising edge.
- R4: Control register 12h bit 3 selects the read-data line. With bit 3 = 1 (3-wire), read data is driven on the shared input line (`sdi_oe` = 1, `sdo_oe` = 0). With bit 3 = 0 (4-wire), read data is driven on `sdo_o` (`sdo_oe` = 1, `sdi_oe` = 0).
- R5: Neither data line is driven while chip select is high or during the command byte.
- R6: With control register 12h bit 2 = 1, the address advances by one after each data byte and wraps from 7Fh to 00h. With bit 2 = 0, every byte of a burst uses the command address, so in a write burst the last byte wins.
- R7: Address 0Fh always reads 69h, and writes to it are ignored.
- R8: If chip select rises in the middle of a data byte, that byte is discarded. Bytes already completed in the same transaction are kept.
- R9: After reset, every register reads 00h except 12h, which reads 04h (4-wire, auto-increment on). Both data lines are released.
- R10: Chip select high returns the block to IDLE. The next chip-select fall starts a fresh command, even if the previous command was cut short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spc_i | input | 1 | Serial clock from the host, idle high |
| cs_n_i | input | 1 | Chip select from the host, active low |
| sdi_i | input | 1 | Serial data input; the shared data line in 3-wire mode |
| sdi_o | output | 1 | Read data for the shared line in 3-wire mode |
| sdi_oe | output | 1 | Drive enable for the shared line |
| sdo_o | output | 1 | Read data on the separate output line |
| sdo_oe | output | 1 | Drive enable for the separate output line |

## Verification
The assertions assume the serial clock stays in each phase for several system clocks, so that every synchronized edge is seen as a separate event. They also assume chip select and the data inputs hold steady across the edges on which they are sampled. The bench holds each serial clock phase for eight system clocks. It changes data only with the falling clock edge, and it moves chip select only while the serial clock is high. In 3-wire reads, the bench releases the shared line and models it as a pad that the slave drives whenever its enable is high.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int          ADDR_W     = 7;
    localparam int          DATA_W     = 8;
    localparam int          SYNC_DEPTH = 2;
    localparam logic [6:0]  ID_ADDR    = 7'h0F;
    localparam logic [7:0]  ID_VALUE   = 8'h69;
    localparam logic [6:0]  CTRL_ADDR  = 7'h12;
    localparam logic [7:0]  CTRL_RESET = 8'h04;
    localparam int          BIT_3WIRE  = 3;
    localparam int          BIT_INCR   = 2;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CMD   = 2'd1,
        S_WDATA = 2'd2,
        S_RDATA = 2'd3
    } spi_state_e;

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/spireg_regfile.sv
module spireg_regfile #(
    parameter int              AW         = 7,
    parameter int              DW         = 8,
    parameter logic [AW-1:0]   ID_ADDR    = 7'h0F,
    parameter logic [DW-1:0]   ID_VALUE   = 8'h69,
    parameter logic [AW-1:0]   CTRL_ADDR  = 7'h12,
    parameter logic [DW-1:0]   CTRL_RESET = 8'h04,
    parameter int              BIT_3WIRE  = 3,
    parameter int              BIT_INCR   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          cfg_3wire_o,
    output logic          cfg_incr_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= (i == int'(CTRL_ADDR)) ? CTRL_RESET : '0;
            end
        end else if (wr_en && (wr_addr != ID_ADDR)) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data     = (rd_addr == ID_ADDR) ? ID_VALUE : mem_q[rd_addr];
    assign cfg_3wire_o = mem_q[CTRL_ADDR][BIT_3WIRE];
    assign cfg_incr_o  = mem_q[CTRL_ADDR][BIT_INCR];

    AST_ID_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != ID_ADDR)); // R7

endmodule

// File: rtl/spireg_engine.sv
module spireg_engine
    import spireg_pkg::*;
#(
    parameter int            AW      = 7,
    parameter int            DW      = 8,
    parameter logic [AW-1:0] ID_ADDR = 7'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spc_s,
    input  logic          cs_s,
    input  logic          din_s,
    input  logic          cfg_3wire,
    input  logic          cfg_incr,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdi_o,
    output logic          sdi_oe,
    output logic          sdo_o,
    output logic          sdo_oe
);

    localparam int            BCW      = $clog2(DW);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    spi_state_e     st_q, st_d;
    logic           spc_d, cs_d;
    logic           spc_rise, spc_fall, cs_fall;
    logic [BCW-1:0] bitcnt_q;
    logic           last_bit;
    logic [DW-2:0]  sh_q;
    logic [AW-1:0]  addr_q, addr_next, cmd_addr;
    logic           cmd_read;
    logic [DW-1:0]  tx_q;
    logic           dout_q, oe_q;
    logic           wr_en_q;
    logic [AW-1:0]  wr_addr_q;
    logic [DW-1:0]  wr_data_q;
    logic           in_data;

    assign spc_rise  = spc_s & ~spc_d;
    assign spc_fall  = ~spc_s & spc_d;
    assign cs_fall   = ~cs_s & cs_d;
    assign last_bit  = (bitcnt_q == LAST_BIT);
    assign cmd_addr  = {sh_q[AW-2:0], din_s};
    assign cmd_read  = sh_q[DW-2];
    assign addr_next = cfg_incr ? (addr_q + 1'b1) : addr_q;
    assign rd_addr   = (st_q == S_CMD) ? cmd_addr : addr_next;
    assign in_data   = (st_q == S_WDATA) || (st_q == S_RDATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: START, TO_WRITE, TO_READ, ABORT/END
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (cs_fall) st_d = S_CMD;
            end
            S_CMD: begin
                if (cs_s) begin
                    st_d = S_IDLE;
                end else if (spc_rise && last_bit) begin
                    st_d = cmd_read ? S_RDATA : S_WDATA;
                end
            end
            S_WDATA, S_RDATA: begin
                if (cs_s) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spc_d     <= 1'b1;
            cs_d      <= 1'b1;
            bitcnt_q  <= '0;
            sh_q      <= '0;
            addr_q    <= '0;
            tx_q      <= '0;
            dout_q    <= 1'b0;
            oe_q      <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            spc_d   <= spc_s;
            cs_d    <= cs_s;
            wr_en_q <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    bitcnt_q <= '0;
                    oe_q     <= 1'b0;
                end
                S_CMD: begin
                    if (!cs_s && spc_rise) begin
                        sh_q     <= {sh_q[DW-3:0], din_s};
                        bitcnt_q <= bitcnt_q + 1'b1;
                        if (last_bit) begin
                            addr_q <= cmd_addr;
                            tx_q   <= rd_data;
                            oe_q   <= cmd_read;
                        end
                    end
                end
                S_WDATA: begin
                    if (!cs_s && spc_rise) begin
                        sh_q     <= {sh_q[DW-3:0], din_s};
                        bitcnt_q <= bitcnt_q + 1'b1;
                        if (last_bit) begin
                            wr_en_q   <= (addr_q != ID_ADDR);
                            wr_addr_q <= addr_q;
                            wr_data_q <= {sh_q, din_s};
                            addr_q    <= addr_next;
                        end
                    end
                end
                S_RDATA: begin
                    if (!cs_s && spc_fall) begin
                        dout_q   <= tx_q[DW-1];
                        bitcnt_q <= bitcnt_q + 1'b1;
                        if (last_bit) begin
                            tx_q   <= rd_data;
                            addr_q <= addr_next;
                        end else begin
                            tx_q <= {tx_q[DW-2:0], 1'b0};
                        end
                    end
                end
                default: oe_q <= 1'b0;
            endcase
            if (cs_s) begin
                oe_q     <= 1'b0;
                bitcnt_q <= '0;
            end
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;
    assign sdi_o   = dout_q;
    assign sdo_o   = dout_q;
    assign sdi_oe  = oe_q & cfg_3wire;
    assign sdo_oe  = oe_q & ~cfg_3wire;

    AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (st_q == S_IDLE)); // R10

    AST_RELEASE_OUTSIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_RDATA) |-> !oe_q); // R5

    AST_WRITE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |=> !wr_en_q); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && $past(in_data) && (addr_q != $past(addr_q)))
        |-> ((addr_q - $past(addr_q)) == AW'(1)) && $past(cfg_incr)); // R6

endmodule

// File: rtl/spireg_top.sv
module spireg_top
    import spireg_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spc_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sdi_o,
    output logic sdi_oe,
    output logic sdo_o,
    output logic sdo_oe
);

    logic [2:0]    sync_q;
    logic          cfg_3wire, cfg_incr;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_en;

    spireg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spc_i, cs_n_i, sdi_i}),
        .q_o   (sync_q)
    );

    spireg_engine #(
        .AW      (AW),
        .DW      (DW),
        .ID_ADDR (AW'(ID_ADDR))
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .spc_s     (sync_q[2]),
        .cs_s      (sync_q[1]),
        .din_s     (sync_q[0]),
        .cfg_3wire (cfg_3wire),
        .cfg_incr  (cfg_incr),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdi_o     (sdi_o),
        .sdi_oe    (sdi_oe),
        .sdo_o     (sdo_o),
        .sdo_oe    (sdo_oe)
    );

    spireg_regfile #(
        .AW         (AW),
        .DW         (DW),
        .ID_ADDR    (AW'(ID_ADDR)),
        .ID_VALUE   (DW'(ID_VALUE)),
        .CTRL_ADDR  (AW'(CTRL_ADDR)),
        .CTRL_RESET (DW'(CTRL_RESET)),
        .BIT_3WIRE  (BIT_3WIRE),
        .BIT_INCR   (BIT_INCR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .cfg_3wire_o (cfg_3wire),
        .cfg_incr_o  (cfg_incr)
    );

endmodule

// File: tb/sim_spireg_top.sv
`timescale 1ns/1ps
module sim_spireg_top;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spc = 1'b1;
    logic cs_n = 1'b1;
    logic host_d = 1'b0;
    logic host_en = 1'b0;
    logic done = 1'b0;
    wire  sdi_o, sdi_oe, sdo_o, sdo_oe;
    wire  pad = sdi_oe ? sdi_o : (host_en & host_d);

    logic [7:0] model [128];
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spireg_top u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .spc_i  (spc),
        .cs_n_i (cs_n),
        .sdi_i  (pad),
        .sdi_o  (sdi_o),
        .sdi_oe (sdi_oe),
        .sdo_o  (sdo_o),
        .sdo_oe (sdo_oe)
    );

    function automatic logic [7:0] rd_exp(input logic [6:0] a);
        return (a == 7'h0F) ? 8'h69 : model[a];
    endfunction

    function automatic logic [7:0] patt(input logic [6:0] a, input int s);
        if (a == 7'h12) return 8'h04;
        return 8'((int'(a) * 29 + s * 71) ^ 8'h5A);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xbegin();
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic xend();
        tick(H);
        cs_n = 1'b1;
        tick(3 * H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb, input bit chk_rel);
        for (int i = 7; i > 7 - nb; i--) begin
            spc = 1'b0;
            host_en = 1'b1;
            host_d = b[i];
            tick(H);
            if (chk_rel && i == 0)
                check("R5 lines released during command", {6'b0, sdi_oe, sdo_oe}, 8'h00);
            spc = 1'b1;
            tick(H);
        end
        host_en = 1'b0;
    endtask

    task automatic recv_byte(input bit m3, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            spc = 1'b0;
            tick(H);
            b[i] = m3 ? pad : sdo_o;
            if (i == 0)
                check("R4 read line select", {6'b0, sdi_oe, sdo_oe}, m3 ? 8'h02 : 8'h01);
            spc = 1'b1;
            tick(H);
        end
    endtask

    task automatic wr1(input logic [6:0] a, input logic [7:0] d);
        xbegin();
        send_bits({1'b0, a}, 8, 1'b1);
        send_bits(d, 8, 1'b0);
        xend();
        if (a != 7'h0F) model[a] = d;
    endtask

    task automatic wr_burst(input logic [6:0] a0, input int n, input int seed);
        logic [6:0] cur;
        logic inc;
        logic [7:0] d;
        cur = a0;
        inc = model[7'h12][2];
        xbegin();
        send_bits({1'b0, a0}, 8, 1'b1);
        for (int k = 0; k < n; k++) begin
            d = patt(cur, seed + k);
            send_bits(d, 8, 1'b0);
            if (cur != 7'h0F) model[cur] = d;
            if (inc) cur = cur + 1'b1;
        end
        xend();
    endtask

    task automatic rd_burst(input logic [6:0] a0, input int n, input string tag);
        logic [6:0] cur;
        logic inc, m3;
        logic [7:0] got;
        cur = a0;
        inc = model[7'h12][2];
        m3  = model[7'h12][3];
        xbegin();
        send_bits({1'b1, a0}, 8, 1'b1);
        for (int k = 0; k < n; k++) begin
            recv_byte(m3, got);
            check(tag, got, rd_exp(cur));
            if (inc) cur = cur + 1'b1;
        end
        xend();
        check("R5 lines released after CS rise", {6'b0, sdi_oe, sdo_oe}, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        model[7'h12] = 8'h04;
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R9 reset state
        check("R9 outputs released at reset", {6'b0, sdi_oe, sdo_oe}, 8'h00);
        rd_burst(7'h12, 1, "R9 control reset value");
        rd_burst(7'h00, 1, "R9 register 00 reset");
        rd_burst(7'h7F, 1, "R9 register 7F reset");

        // R1 R2 R3 single accesses
        wr1(7'h05, 8'hA5);
        rd_burst(7'h05, 1, "R2 R3 single write then read");
        wr1(7'h2A, 8'h3C);
        rd_burst(7'h2B, 1, "R1 neighbour address untouched");
        rd_burst(7'h2A, 1, "R1 address decode");
        wr1(7'h55, 8'hC3);
        rd_burst(7'h55, 1, "R1 R3 alternating address bits");

        // R7 identity
        rd_burst(7'h0F, 1, "R7 identity value");
        wr1(7'h0F, 8'h00);
        rd_burst(7'h0F, 1, "R7 identity write ignored");

        // R6 full auto-increment sweep, 4-wire
        wr_burst(7'h00, 128, 3);
        rd_burst(7'h00, 128, "R6 R3 incrementing burst sweep");
        wr_burst(7'h7E, 4, 11);
        rd_burst(7'h7E, 4, "R6 address wrap 7F to 00");

        // R6 increment off: last byte wins
        wr1(7'h12, 8'h00);
        wr_burst(7'h20, 3, 40);
        rd_burst(7'h20, 3, "R6 no increment repeated address");
        rd_burst(7'h21, 1, "R6 no increment neighbour untouched");
        wr1(7'h12, 8'h04);

        // R4 3-wire mode
        wr1(7'h12, 8'h0C);
        rd_burst(7'h00, 20, "R4 3-wire burst read");
        wr1(7'h40, 8'h5A);
        rd_burst(7'h40, 1, "R4 3-wire single read");
        wr1(7'h12, 8'h04);
        rd_burst(7'h40, 2, "R4 back to 4-wire");

        // R8 abort mid data byte
        xbegin();
        send_bits({1'b0, 7'h30}, 8, 1'b1);
        send_bits(8'h77, 8, 1'b0);
        send_bits(8'hEE, 4, 1'b0);
        xend();
        model[7'h30] = 8'h77;
        rd_burst(7'h30, 1, "R8 completed byte kept");
        rd_burst(7'h31, 1, "R8 partial byte discarded");

        // R10 aborted command, then fresh transaction
        xbegin();
        send_bits({1'b1, 7'h05}, 3, 1'b0);
        xend();
        check("R10 released after aborted command", {6'b0, sdi_oe, sdo_oe}, 8'h00);
        rd_burst(7'h05, 1, "R10 fresh command after abort");
        wr1(7'h06, 8'h81);
        rd_burst(7'h06, 1, "R10 write after abort");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule